// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two 8-bit buses, called A and B. Each direction has its own storage register, its own capture strobe, a source select and an output enable. The bus that faces B can carry two values: the live value seen on bus A, or the copy of A held in the A-side register. The bus that faces A works the same way, using bus B and the B-side register. Both data paths invert, so whatever is driven onto a bus is the bitwise complement of the chosen source. The two enables have opposite polarity: the B-facing enable is active high and the A-facing enable is active low.

Neither bus is an inout pin. For each bus the block takes the resolved bus value as an input and gives back a drive value and a per-bit output-enable vector. The surrounding logic, or a bench, resolves the physical bus from these. Capture strobes are sampled in the `clk` domain. A register loads its bus when its strobe is high in a cycle where it was low in the cycle before. This happens whatever the select and enable settings are. All pins are plain control and data; there is no handshake at the block's edge.

Top module: `dual_reg_xcvr`

## Requirements
- R1: After the synchronous active-low reset `rst_n`, both storage registers hold 0x00. With both stored selects high and both sides driving, both buses are driven to 0xFF.
- R2: A rising edge on `a_cap` stores the value on `a_in` at that clock edge. The store happens for any setting of selects and enables, and the stored value can then be driven onto B.
- R3: A rising edge on `b_cap` stores the value on `b_in` at that clock edge. The store happens for any setting of selects and enables, and the stored value can then be driven onto A.
- R4: `b_out` is the complement of `a_in` when `b_src_reg` is 0. It is the complement of the A-side register when `b_src_reg` is 1.
- R5: `a_out` is the complement of `b_in` when `a_src_reg` is 0. It is the complement of the B-side register when `a_src_reg` is 1.
- R6: `b_oe` is all ones when `b_drv_en` is 1 and all zeros otherwise. `a_oe` is all ones when `a_drv_en_n` is 0 and all zeros otherwise.
- R7: A strobe held high stores only once, in the first cycle. Later bus changes leave the register unchanged until the strobe falls and rises again.
- R8: When both strobes rise in the same cycle, both registers load the bus values present before that edge. With both sides driving from storage, this swaps the two registers through the inverting paths: each register gets the complement of the other.
- R9: With `b_drv_en` at 0 and `a_drv_en_n` at 1, no output-enable bit is set, and strobe edges still store both buses.
- R10: With both sides driving live data and no outside source, each bus output reinforces the other, so both buses hold their last values.
- R11: A bus captured while the other side drives it live stores the complement of that driving source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for strobes and registers |
| rst_n | input | 1 | Synchronous active-low reset |
| a_cap | input | 1 | Strobe; its rising edge stores bus A |
| b_cap | input | 1 | Strobe; its rising edge stores bus B |
| b_src_reg | input | 1 | 1: B is driven from the A register; 0: from live A |
| a_src_reg | input | 1 | 1: A is driven from the B register; 0: from live B |
| b_drv_en | input | 1 | Active-high enable for driving bus B |
| a_drv_en_n | input | 1 | Active-low enable for driving bus A |
| a_in | input | 8 | Resolved value on bus A |
| a_out | output | 8 | Value this block drives onto bus A |
| a_oe | output | 8 | Per-bit drive enable for bus A |
| b_in | input | 8 | Resolved value on bus B |
| b_out | output | 8 | Value this block drives onto bus B |
| b_oe | output | 8 | Per-bit drive enable for bus B |

## Verification
The case to watch is a store and a drive from that same register falling in one cycle. This comes up most sharply when both strobes rise together while both sides drive from storage, so each register captures a bus that the other register is driving. The bench sets this up from known register contents and expects the two stored values to swap through the inverters, as R8 states. Its bus model, with keepers and outside drivers, is reproduced every cycle, so the live reinforcing loop and the store of a bus driven by this block are judged the same way.

// File: rtl/dual_reg_xcvr_pkg.sv
`timescale 1ns/1ps
package dual_reg_xcvr_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;
endpackage

// File: rtl/xcvr_store.sv
`timescale 1ns/1ps
module xcvr_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic cap_q;
  logic rise;

  assign rise = cap & ~cap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q <= 1'b0;
      q     <= '0;
    end else begin
      cap_q <= cap;
      if (rise) q <= d;
    end
  end

  AST_EDGE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !cap_q) |=> (q == $past(d))); // R2

  AST_NO_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap || cap_q) |=> $stable(q)); // R7
endmodule

// File: rtl/xcvr_drive.sv
`timescale 1ns/1ps
module xcvr_drive
  import dual_reg_xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  src_sel_e     sel,
  input  logic         en,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] dout,
  output logic [W-1:0] oe
);
  logic [W-1:0] chosen;

  always_comb begin
    chosen = (sel == SRC_STORED) ? stored : live;
    dout   = ~chosen;
  end

  for (genvar i = 0; i < W; i++) begin : g_oe
    assign oe[i] = en;
  end
endmodule

// File: rtl/dual_reg_xcvr.sv
`timescale 1ns/1ps
module dual_reg_xcvr
  import dual_reg_xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_cap,
  input  logic         b_cap,
  input  logic         b_src_reg,
  input  logic         a_src_reg,
  input  logic         b_drv_en,
  input  logic         a_drv_en_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);
  logic [W-1:0] reg_a;
  logic [W-1:0] reg_b;
  src_sel_e     sel_b;
  src_sel_e     sel_a;

  assign sel_b = src_sel_e'(b_src_reg);
  assign sel_a = src_sel_e'(a_src_reg);

  xcvr_store #(.W(W)) u_store_a (
    .clk(clk), .rst_n(rst_n), .cap(a_cap), .d(a_in), .q(reg_a)
  );

  xcvr_store #(.W(W)) u_store_b (
    .clk(clk), .rst_n(rst_n), .cap(b_cap), .d(b_in), .q(reg_b)
  );

  xcvr_drive #(.W(W)) u_drive_b (
    .sel(sel_b), .en(b_drv_en), .live(a_in), .stored(reg_a),
    .dout(b_out), .oe(b_oe)
  );

  xcvr_drive #(.W(W)) u_drive_a (
    .sel(sel_a), .en(~a_drv_en_n), .live(b_in), .stored(reg_b),
    .dout(a_out), .oe(a_oe)
  );

  AST_B_LIVE_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_src_reg) |-> (b_out == ~a_in)); // R4

  AST_A_LIVE_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_src_reg) |-> (a_out == ~b_in)); // R5

  AST_ISOLATED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_drv_en && a_drv_en_n) |-> ((a_oe | b_oe) == '0)); // R9
endmodule

// File: tb/dual_reg_xcvr_tb.sv
`timescale 1ns/1ps
module dual_reg_xcvr_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       a_cap, b_cap, b_src_reg, a_src_reg, b_drv_en, a_drv_en_n;
  logic [7:0] a_in, b_in;
  logic [7:0] a_out, a_oe, b_out, b_oe;

  logic       ea_en, eb_en;
  logic [7:0] ea_val, eb_val;

  logic [7:0] m_ra, m_rb;
  logic       m_pa, m_pb;
  int         vectors = 0;
  int         fails = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  dual_reg_xcvr u_dut (
    .clk(clk), .rst_n(rst_n), .a_cap(a_cap), .b_cap(b_cap),
    .b_src_reg(b_src_reg), .a_src_reg(a_src_reg),
    .b_drv_en(b_drv_en), .a_drv_en_n(a_drv_en_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  // reference storage model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ra <= 8'h00; m_rb <= 8'h00; m_pa <= 1'b0; m_pb <= 1'b0;
    end else begin
      if (a_cap && !m_pa) m_ra <= a_in;
      if (b_cap && !m_pb) m_rb <= b_in;
      m_pa <= a_cap;
      m_pb <= b_cap;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      chk("R4", b_out, ~(b_src_reg ? m_ra : a_in));
      chk("R5", a_out, ~(a_src_reg ? m_rb : b_in));
      chk("R6", b_oe, {8{b_drv_en}});
      chk("R6", a_oe, {8{~a_drv_en_n}});
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // bus resolution: outside driver, else this block, else keeper
  task automatic settle();
    repeat (4) begin
      #0.2;
      a_in = ea_en ? ea_val : (a_oe[0] ? a_out : a_in);
      b_in = eb_en ? eb_val : (b_oe[0] ? b_out : b_in);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; a_cap = 0; b_cap = 0; b_src_reg = 0; a_src_reg = 0;
    b_drv_en = 0; a_drv_en_n = 1; ea_en = 0; eb_en = 0;
    ea_val = 0; eb_val = 0; a_in = 0; b_in = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1; settle();

    // R1 reset contents through stored drive; R6 enables
    tick(); a_src_reg = 1; b_src_reg = 1; b_drv_en = 1; a_drv_en_n = 0; settle();
    chk("R1", b_out, 8'hFF); chk("R1", a_out, 8'hFF);
    chk("R6", a_oe & b_oe, 8'hFF);

    // R9 isolation with simultaneous captures
    tick(); b_drv_en = 0; a_drv_en_n = 1; ea_en = 1; ea_val = 8'h3C;
    eb_en = 1; eb_val = 8'hA5; settle();
    chk("R9", a_oe | b_oe, 8'h00);
    tick(); a_cap = 1; b_cap = 1; settle();
    tick(); a_cap = 0; b_cap = 0; ea_val = 8'h00; eb_val = 8'h00; settle();
    tick(); eb_en = 0; b_drv_en = 1; settle();
    chk("R2", b_out, 8'hC3);
    chk("R6", a_oe, 8'h00);
    tick(); ea_en = 0; a_drv_en_n = 0; settle();
    chk("R3", a_out, 8'h5A);

    // R8 swap through inverting paths
    tick(); a_cap = 1; b_cap = 1; settle();
    tick(); a_cap = 0; b_cap = 0; settle();
    chk("R8", b_out, 8'hA5); chk("R8", a_out, 8'h3C);

    // R7 held strobe stores once
    tick(); b_drv_en = 0; a_drv_en_n = 1; ea_en = 1; ea_val = 8'h11;
    eb_en = 1; eb_val = 8'h22; a_cap = 1; settle();
    tick(); ea_val = 8'h77; settle();
    tick(); ea_val = 8'h88; settle();
    tick(); a_cap = 0; eb_en = 0; b_drv_en = 1; b_src_reg = 1; settle();
    chk("R7", b_out, 8'hEE);

    // R4 live A to B
    tick(); b_src_reg = 0; settle();
    foreach (ea_val[i]) begin end
    for (int k = 0; k < 6; k++) begin
      logic [7:0] v;
      v = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'hA5 :
          (k == 3) ? 8'h5A : (k == 4) ? 8'h01 : 8'h80;
      tick(); ea_val = v; settle();
      chk("R4", b_out, ~v);
    end

    // R5 live B to A
    tick(); b_drv_en = 0; eb_en = 1; eb_val = 8'h00; ea_en = 0;
    a_drv_en_n = 0; a_src_reg = 0; settle();
    for (int k = 0; k < 5; k++) begin
      logic [7:0] v;
      v = 8'h0F << k;
      tick(); eb_val = v; settle();
      chk("R5", a_out, ~v);
    end

    // R11 capture of a bus this block drives
    tick(); a_drv_en_n = 1; eb_en = 0; b_drv_en = 1; b_src_reg = 0;
    ea_en = 1; ea_val = 8'h5A; settle();
    chk("R11", b_in, 8'hA5);
    tick(); b_cap = 1; settle();
    tick(); b_cap = 0; settle();
    tick(); b_drv_en = 0; eb_en = 1; eb_val = 8'h00; ea_en = 0;
    a_drv_en_n = 0; a_src_reg = 1; settle();
    chk("R11", a_out, 8'h5A);

    // R10 reinforcing loop holds the buses
    tick(); eb_en = 0; b_drv_en = 1; a_src_reg = 0; b_src_reg = 0;
    a_drv_en_n = 1; ea_en = 1; ea_val = 8'h96; settle();
    tick(); a_drv_en_n = 0; settle();
    chk("R10", b_in, 8'h69);
    tick(); ea_en = 0; settle();
    repeat (3) begin tick(); settle(); end
    chk("R10", a_in, 8'h96); chk("R10", b_in, 8'h69);

    tick(); tick();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule